// File: doc/BRIEF.md
# Multiplexed Asynchronous Parallel Memory Port

This block lets an on-chip agent read and write 32-bit words in slow asynchronous external memory through a single set of 16 shared lines. Each external access is split in time. An address phase puts the address on the lines while a latch strobe loads it into an external address latch. A data phase follows, in which a read or a write strobe is held low for a programmable number of core clock cycles.

Two bus modes are available, chosen per request. The 8-bit mode reaches a 24-bit address space: the upper 16 address bits go through the latch, and the lowest 8 bits ride on the upper byte lane during the data phase. The 16-bit mode uses a 16-bit latched address and 16-bit data. A word request becomes four byte beats or two half-word beats at consecutive external addresses. Beats are packed or unpacked little-endian, and one acknowledge pulse marks the end of the word.

The internal side is a level request held until the acknowledge pulse. Mode, strobe width, address, direction and write data are all captured when the request is accepted.

Top module: `mux_mem_port`

## Requirements
- R1: While `rst` is high and in the idle state after it, `ale` and `req_ack` are 0, `rd_stb_n` and `wr_stb_n` are 1, `bus_oe` is 00, and after reset `rsp_rdata` is 0.
- R2: A beat opens with `ale` high for exactly one cycle, with both lanes driven (`bus_oe` = 11). The bus carries address bits [15:0] when `cfg_wide` = 1 (16-bit mode) and bits [23:8] when `cfg_wide` = 0 (8-bit mode).
- R3: The cycle after `ale` keeps the bus value and both lane enables unchanged with no strobe active, and the strobe starts in the next cycle. Reads assert only `rd_stb_n` and writes only `wr_stb_n` (both active low), never together and never while `ale` is high.
- R4: The strobe stays low for exactly `cfg_len` cycles for values 2 to 31; values 0 and 1 give 2 cycles.
- R5: During a write strobe both lanes are driven. In 16-bit mode beat k carries `req_wdata[16k+15:16k]`. In 8-bit mode the low lane carries `req_wdata[8k+7:8k]` and the high lane carries address bits [7:0].
- R6: During a read strobe, 16-bit mode releases both lanes (`bus_oe` = 00). 8-bit mode releases only the low lane (`bus_oe` = 10, bit 1 being `bus[15:8]`) and keeps address bits [7:0] on the high lane. Read data is taken from `bus_in` on the last strobe cycle, and in 8-bit mode `bus_in[15:8]` is ignored.
- R7: A word takes 4 beats in 8-bit mode and 2 in 16-bit mode. The beat address rises by one each beat, with the full 24-bit carry into the latched part. Each later beat's `ale` comes in the cycle right after the previous strobe's last cycle.
- R8: Read beats are packed little-endian: beat k fills byte k (8-bit mode) or half-word k (16-bit mode) of `rsp_rdata`.
- R9: `req_ack` is high for exactly one cycle, the cycle after the last strobe cycle of the word. `rsp_rdata` holds the packed read word in that cycle.
- R10: Changes of `cfg_wide`, `cfg_len`, `req_addr`, `req_wdata` or `req_write` after a request is accepted have no effect on the word in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Word request, held until `req_ack` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | External address of the first beat |
| req_wdata | input | 32 | Write word |
| cfg_wide | input | 1 | 1 = 16-bit mode, 0 = 8-bit mode |
| cfg_len | input | 5 | Strobe width in core cycles |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Packed read word |
| bus_out | output | 16 | Value driven on the shared lines |
| bus_oe | output | 2 | Lane drive enables: bit 1 upper byte, bit 0 lower byte |
| bus_in | input | 16 | Value sampled from the shared lines |
| ale | output | 1 | Address latch strobe, active high |
| rd_stb_n | output | 1 | Read strobe, active low |
| wr_stb_n | output | 1 | Write strobe, active low |

## Verification
The request is accepted at the first rising edge that sees `req_valid`. The first `ale` is high during the following cycle, the hold cycle comes after it, and the strobe runs from the third cycle for the strobe width. Each next beat starts right away, and `req_ack` rises one cycle after the last strobe cycle, so a word takes beats × (width + 2) + 1 cycles. The bench drives at falling edges and samples at falling edges. It follows that fixed order beat by beat from the latch strobe, and compares the counted strobe width with the expected one. Read data is presented on `bus_in` through each strobe so that the sample on the last strobe edge is checked through `rsp_rdata` in the acknowledge cycle.

// File: rtl/mmp_pkg.sv
package mmp_pkg;

    localparam int MMP_ADDR_W  = 24;
    localparam int MMP_WORD_W  = 32;
    localparam int MMP_BUS_W   = 16;
    localparam int MMP_LEN_W   = 5;
    localparam int MMP_MIN_LEN = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALE,
        ST_HOLD,
        ST_STROBE,
        ST_ACK
    } mmp_state_e;

    // transfer attributes captured at acceptance
    typedef struct packed {
        logic write;
        logic wide;
    } mmp_mode_t;

    // per-cycle phase flags from the sequencer
    typedef struct packed {
        logic start;
        logic ale;
        logic addr_drv;
        logic data;
        logic sample;
        logic ack;
    } mmp_phase_t;

    function automatic int units_per_word(int word_w, int unit_w);
        return word_w / unit_w;
    endfunction

    function automatic int idx_width(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mmp_seq.sv
module mmp_seq
    import mmp_pkg::*;
#(
    parameter int ADDR_W  = MMP_ADDR_W,
    parameter int WORD_W  = MMP_WORD_W,
    parameter int LEN_W   = MMP_LEN_W,
    parameter int MIN_LEN = MMP_MIN_LEN,
    parameter int NB      = 4,
    parameter int NH      = 2,
    parameter int BEAT_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic              cfg_wide,
    input  logic [LEN_W-1:0]  cfg_len,
    output mmp_mode_t         mode,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [BEAT_W-1:0] beat,
    output logic [WORD_W-1:0] wdata,
    output mmp_phase_t        phase
);

    mmp_state_e        state;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  cnt;
    logic [LEN_W-1:0]  len_eff;
    logic [BEAT_W-1:0] last_idx;
    logic              strobe_end;

    assign len_eff    = (cfg_len < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) : cfg_len;
    assign last_idx   = mode.wide ? BEAT_W'(NH - 1) : BEAT_W'(NB - 1);
    assign strobe_end = (state == ST_STROBE) && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            mode     <= '0;
            len_q    <= LEN_W'(MIN_LEN);
            cnt      <= '0;
            beat     <= '0;
            cur_addr <= '0;
            wdata    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        mode     <= '{write: req_write, wide: cfg_wide};
                        len_q    <= len_eff;
                        cur_addr <= req_addr;
                        wdata    <= req_wdata;
                        beat     <= '0;
                        state    <= ST_ALE;
                    end
                end
                ST_ALE: state <= ST_HOLD;
                ST_HOLD: begin
                    cnt   <= len_q - LEN_W'(1);
                    state <= ST_STROBE;
                end
                ST_STROBE: begin
                    if (cnt == '0) begin
                        if (beat == last_idx) begin
                            state <= ST_ACK;
                        end else begin
                            beat     <= beat + BEAT_W'(1);
                            cur_addr <= cur_addr + ADDR_W'(1);
                            state    <= ST_ALE;
                        end
                    end else begin
                        cnt <= cnt - LEN_W'(1);
                    end
                end
                ST_ACK:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        phase          = '0;
        phase.start    = (state == ST_IDLE) && req_valid;
        phase.ale      = (state == ST_ALE);
        phase.addr_drv = (state == ST_ALE) || (state == ST_HOLD);
        phase.data     = (state == ST_STROBE);
        phase.sample   = strobe_end && !mode.write;
        phase.ack      = (state == ST_ACK);
    end

endmodule

// File: rtl/mmp_lane.sv
module mmp_lane
    import mmp_pkg::*;
#(
    parameter int ADDR_W = MMP_ADDR_W,
    parameter int WORD_W = MMP_WORD_W,
    parameter int BUS_W  = MMP_BUS_W,
    parameter int BEAT_W = 2
) (
    input  logic              addr_drv,
    input  logic              data_drv,
    input  mmp_mode_t         mode,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [BEAT_W-1:0] beat,
    input  logic [WORD_W-1:0] wdata,
    output logic [BUS_W-1:0]  bus_out,
    output logic [1:0]        bus_oe
);

    localparam int LANE_W = BUS_W / 2;
    localparam int NB     = units_per_word(WORD_W, LANE_W);
    localparam int NH     = units_per_word(WORD_W, BUS_W);
    localparam int HB     = idx_width(NH);

    logic [LANE_W-1:0] byte_sel [NB];
    logic [BUS_W-1:0]  half_sel [NH];

    for (genvar i = 0; i < NB; i++) begin : g_byte
        assign byte_sel[i] = wdata[i*LANE_W +: LANE_W];
    end

    for (genvar j = 0; j < NH; j++) begin : g_half
        assign half_sel[j] = wdata[j*BUS_W +: BUS_W];
    end

    always_comb begin
        bus_out = '0;
        bus_oe  = 2'b00;
        if (addr_drv) begin
            bus_oe  = 2'b11;
            bus_out = mode.wide ? cur_addr[BUS_W-1:0] : cur_addr[ADDR_W-1 -: BUS_W];
        end else if (data_drv) begin
            if (mode.wide) begin
                bus_out = half_sel[beat[HB-1:0]];
                bus_oe  = {2{mode.write}};
            end else begin
                // upper lane completes the address, lower lane carries the byte
                bus_out = {cur_addr[LANE_W-1:0], byte_sel[beat]};
                bus_oe  = {1'b1, mode.write};
            end
        end
    end

endmodule

// File: rtl/mmp_pack.sv
module mmp_pack
    import mmp_pkg::*;
#(
    parameter int WORD_W = MMP_WORD_W,
    parameter int BUS_W  = MMP_BUS_W,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              sample,
    input  logic              wide,
    input  logic [BEAT_W-1:0] beat,
    input  logic [BUS_W-1:0]  bus_in,
    output logic [WORD_W-1:0] rdata
);

    localparam int LANE_W   = BUS_W / 2;
    localparam int NB       = units_per_word(WORD_W, LANE_W);
    localparam int PER_HALF = BUS_W / LANE_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (start) begin
            rdata <= '0;
        end else if (sample) begin
            for (int k = 0; k < NB; k++) begin
                if (wide ? (int'(beat) == k / PER_HALF) : (int'(beat) == k)) begin
                    rdata[k*LANE_W +: LANE_W] <= wide ? bus_in[(k % PER_HALF)*LANE_W +: LANE_W]
                                                      : bus_in[LANE_W-1:0];
                end
            end
        end
    end

endmodule

// File: rtl/mux_mem_port.sv
module mux_mem_port
    import mmp_pkg::*;
#(
    parameter int ADDR_W  = MMP_ADDR_W,
    parameter int WORD_W  = MMP_WORD_W,
    parameter int BUS_W   = MMP_BUS_W,
    parameter int LEN_W   = MMP_LEN_W,
    parameter int MIN_LEN = MMP_MIN_LEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic              cfg_wide,
    input  logic [LEN_W-1:0]  cfg_len,
    output logic              req_ack,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic [BUS_W-1:0]  bus_out,
    output logic [1:0]        bus_oe,
    input  logic [BUS_W-1:0]  bus_in,
    output logic              ale,
    output logic              rd_stb_n,
    output logic              wr_stb_n
);

    localparam int LANE_W = BUS_W / 2;
    localparam int NB     = units_per_word(WORD_W, LANE_W);
    localparam int NH     = units_per_word(WORD_W, BUS_W);
    localparam int BEAT_W = idx_width(NB);

    mmp_mode_t         mode;
    mmp_phase_t        phase;
    logic [ADDR_W-1:0] cur_addr;
    logic [BEAT_W-1:0] beat;
    logic [WORD_W-1:0] wdata;

    mmp_seq #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .LEN_W  (LEN_W),
        .MIN_LEN(MIN_LEN),
        .NB     (NB),
        .NH     (NH),
        .BEAT_W (BEAT_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .cfg_wide (cfg_wide),
        .cfg_len  (cfg_len),
        .mode     (mode),
        .cur_addr (cur_addr),
        .beat     (beat),
        .wdata    (wdata),
        .phase    (phase)
    );

    mmp_lane #(
        .ADDR_W(ADDR_W),
        .WORD_W(WORD_W),
        .BUS_W (BUS_W),
        .BEAT_W(BEAT_W)
    ) u_lane (
        .addr_drv(phase.addr_drv),
        .data_drv(phase.data),
        .mode    (mode),
        .cur_addr(cur_addr),
        .beat    (beat),
        .wdata   (wdata),
        .bus_out (bus_out),
        .bus_oe  (bus_oe)
    );

    mmp_pack #(
        .WORD_W(WORD_W),
        .BUS_W (BUS_W),
        .BEAT_W(BEAT_W)
    ) u_pack (
        .clk   (clk),
        .rst   (rst),
        .start (phase.start),
        .sample(phase.sample),
        .wide  (mode.wide),
        .beat  (beat),
        .bus_in(bus_in),
        .rdata (rsp_rdata)
    );

    assign ale      = phase.ale;
    assign req_ack  = phase.ack;
    assign rd_stb_n = !(phase.data && !mode.write);
    assign wr_stb_n = !(phase.data && mode.write);

endmodule

// File: rtl/mmp_checker.sv
module mmp_checker #(
    parameter int BUS_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             ale,
    input logic             rd_stb_n,
    input logic             wr_stb_n,
    input logic [BUS_W-1:0] bus_out,
    input logic [1:0]       bus_oe,
    input logic             req_ack
);

    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (rst) ale |=> !ale); // R2
    AST_ALE_BOTH_LANES: assert property (@(posedge clk) disable iff (rst) ale |-> bus_oe == 2'b11); // R2
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
        ale |=> (rd_stb_n && wr_stb_n && $stable(bus_out) && bus_oe == 2'b11)); // R3
    AST_RD_AFTER_HOLD: assert property (@(posedge clk) disable iff (rst) $fell(rd_stb_n) |-> $past(ale, 2)); // R3
    AST_WR_AFTER_HOLD: assert property (@(posedge clk) disable iff (rst) $fell(wr_stb_n) |-> $past(ale, 2)); // R3
    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(!rd_stb_n && !wr_stb_n) && !(ale && (!rd_stb_n || !wr_stb_n))); // R3
    AST_RD_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst) $fell(rd_stb_n) |=> !rd_stb_n); // R4
    AST_WR_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst) $fell(wr_stb_n) |=> !wr_stb_n); // R4
    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (rst) !wr_stb_n |-> bus_oe == 2'b11); // R5
    AST_READ_LOW_FREE: assert property (@(posedge clk) disable iff (rst) !rd_stb_n |-> !bus_oe[0]); // R6
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst) req_ack |=> !req_ack); // R9
    AST_ACK_QUIET_BUS: assert property (@(posedge clk) disable iff (rst)
        req_ack |-> (rd_stb_n && wr_stb_n && !ale && bus_oe == 2'b00)); // R9

endmodule

bind mux_mem_port mmp_checker #(.BUS_W(BUS_W)) u_mmp_chk (
    .clk     (clk),
    .rst     (rst),
    .ale     (ale),
    .rd_stb_n(rd_stb_n),
    .wr_stb_n(wr_stb_n),
    .bus_out (bus_out),
    .bus_oe  (bus_oe),
    .req_ack (req_ack)
);

// File: tb/tb_mux_mem_port.sv
module tb_mux_mem_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        cfg_wide = 1'b0;
    logic [4:0]  cfg_len = 5'd2;
    logic        req_ack;
    logic [31:0] rsp_rdata;
    logic [15:0] bus_out;
    logic [1:0]  bus_oe;
    logic [15:0] bus_in = '0;
    logic        ale;
    logic        rd_stb_n;
    logic        wr_stb_n;

    always #5 clk = ~clk;

    mux_mem_port dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .cfg_wide(cfg_wide),
        .cfg_len(cfg_len), .req_ack(req_ack), .rsp_rdata(rsp_rdata),
        .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in), .ale(ale),
        .rd_stb_n(rd_stb_n), .wr_stb_n(wr_stb_n)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    typedef struct {
        logic [15:0] abus;
        logic [15:0] dbus;
        logic [1:0]  doe;
        int          len;
        bit          wr;
        bit          wide;
        logic [15:0] rin;
        bit          last;
    } beat_t;

    typedef struct {
        bit          wr;
        logic [31:0] rdata;
    } word_t;

    beat_t beat_q[$];
    word_t word_q[$];
    word_t got_w;

    function automatic logic [15:0] rd_val(logic [23:0] a);
        return {a[7:0] ^ 8'h3C, a[15:8] ^ a[7:0] ^ 8'h96};
    endfunction

    // driver: queue the expected beats and word, then run the request
    task automatic do_word(input bit wr, input bit wide, input logic [4:0] lenc,
                           input logic [23:0] addr, input logic [31:0] wd, input bit scramble);
        int    nb  = wide ? 2 : 4;
        int    len = (lenc < 5'd2) ? 2 : int'(lenc);
        word_t w;
        w.wr = wr;
        w.rdata = '0;
        for (int k = 0; k < nb; k++) begin
            beat_t       b;
            logic [23:0] a;
            logic [15:0] r;
            a = addr + 24'(k);
            r = rd_val(a);
            b.abus = wide ? a[15:0] : a[23:8];
            b.len  = len;
            b.wr   = wr;
            b.wide = wide;
            b.rin  = r;
            b.last = (k == nb - 1);
            if (wide) begin
                b.dbus = wd[k*16 +: 16];
                b.doe  = wr ? 2'b11 : 2'b00;
                if (!wr) w.rdata[k*16 +: 16] = r;
            end else begin
                b.dbus = {a[7:0], wd[k*8 +: 8]};
                b.doe  = wr ? 2'b11 : 2'b10;
                if (!wr) w.rdata[k*8 +: 8] = r[7:0];
            end
            beat_q.push_back(b);
        end
        word_q.push_back(w);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        cfg_wide  = wide;
        cfg_len   = lenc;
        req_addr  = addr;
        req_wdata = wd;
        @(negedge clk);
        if (scramble) begin
            cfg_wide  = !wide;
            cfg_len   = 5'd31;
            req_addr  = ~addr;
            req_wdata = ~wd;
            req_write = !wr;
        end
        while (!req_ack) @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor: follows each beat from its latch strobe
    initial begin
        bit    pend;
        beat_t cur;
        int    n;
        pend = 0;
        wait (!rst);
        forever begin
            if (!pend) @(negedge clk);
            pend = 0;
            if (ale) begin
                if (beat_q.size() == 0) begin
                    chk(0, "R7 unexpected latch strobe", {16'd0, bus_out}, 0);
                end else begin
                    cur = beat_q.pop_front();
                    chk(bus_out == cur.abus && bus_oe == 2'b11, "R2 address phase",
                        {14'd0, bus_oe, bus_out}, {14'd0, 2'b11, cur.abus});
                    chk(rd_stb_n && wr_stb_n, "R3 no strobe with latch", {rd_stb_n, wr_stb_n}, 2'b11);
                    @(negedge clk);
                    chk(!ale && rd_stb_n && wr_stb_n && bus_out == cur.abus && bus_oe == 2'b11,
                        "R3 hold cycle", {12'd0, ale, rd_stb_n, wr_stb_n, bus_oe[0], bus_out},
                        {12'd0, 4'b0111, cur.abus});
                    @(negedge clk);
                    n = 0;
                    while (!rd_stb_n || !wr_stb_n) begin
                        chk(cur.wr ? (!wr_stb_n && rd_stb_n) : (!rd_stb_n && wr_stb_n),
                            "R3 strobe kind", {rd_stb_n, wr_stb_n}, cur.wr ? 2'b10 : 2'b01);
                        chk(bus_oe == cur.doe, cur.wr ? "R5 write lane enables" : "R6 read lane release",
                            bus_oe, cur.doe);
                        if (cur.wr) begin
                            chk(bus_out == cur.dbus, "R5 write data", bus_out, cur.dbus);
                        end else begin
                            if (!cur.wide)
                                chk(bus_out[15:8] == cur.dbus[15:8], "R6 address byte during read",
                                    bus_out[15:8], cur.dbus[15:8]);
                            bus_in = cur.rin;
                        end
                        n++;
                        @(negedge clk);
                    end
                    bus_in = 16'h0000;
                    chk(n == cur.len, "R4 strobe length", n, cur.len);
                    if (cur.last)
                        chk(req_ack, "R9 acknowledge timing", req_ack, 1);
                    else
                        chk(ale && !req_ack, "R7 next beat follows", {ale, req_ack}, 2'b10);
                    pend = 1;
                end
            end
        end
    end

    // monitor: acknowledge and packed read word
    always @(negedge clk) begin
        if (!rst && req_ack) begin
            if (word_q.size() == 0) begin
                chk(0, "R9 spurious acknowledge", 1, 0);
            end else begin
                got_w = word_q.pop_front();
                if (!got_w.wr) chk(rsp_rdata == got_w.rdata, "R8 packed read word", rsp_rdata, got_w.rdata);
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!ale && rd_stb_n && wr_stb_n && bus_oe == 2'b00 && !req_ack, "R1 outputs in reset",
            {ale, rd_stb_n, wr_stb_n, bus_oe, req_ack}, 6'b011000);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!ale && rd_stb_n && wr_stb_n && bus_oe == 2'b00 && !req_ack, "R1 idle after reset",
            {ale, rd_stb_n, wr_stb_n, bus_oe, req_ack}, 6'b011000);
        chk(rsp_rdata == 32'd0, "R1 read word cleared", rsp_rdata, 0);

        do_word(1, 1, 5'd2,  24'h001234, 32'hDEADBEEF, 0);   // R5 16-bit write
        do_word(0, 1, 5'd5,  24'h00FFFF, 32'h0,        0);   // R6 R8 16-bit read, address wrap
        do_word(1, 0, 5'd3,  24'h1234FE, 32'hA1B2C3D4, 0);   // R5 R7 8-bit write, carry into latch
        do_word(0, 0, 5'd31, 24'hABCDFD, 32'h0,        0);   // R6 R8 8-bit read, longest strobe
        do_word(0, 0, 5'd0,  24'h000010, 32'h0,        0);   // R4 width 0 gives 2
        do_word(1, 1, 5'd1,  24'h00BEEF, 32'h01234567, 0);   // R4 width 1 gives 2
        do_word(0, 0, 5'd4,  24'h7F00F0, 32'h0,        1);   // R10 inputs changed while busy
        repeat (3) @(negedge clk);
        chk(beat_q.size() == 0 && word_q.size() == 0, "R10 word finished with captured settings",
            beat_q.size() + word_q.size(), 0);
        do_word(1, 0, 5'd2,  24'hFFFFFE, 32'h5A5AA5A5, 1);   // R10 write held, 24-bit wrap
        do_word(0, 1, 5'd7,  24'h00FFFE, 32'h0,        0);   // R8 back to back
        repeat (10) @(negedge clk);
        chk(beat_q.size() == 0 && word_q.size() == 0, "R7 all beats seen",
            beat_q.size() + word_q.size(), 0);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule